// File: doc/BRIEF.md
# Programmable Word Aligner for Deserialized 10-bit Streams

A deserializer hands over 10-bit parallel words whose boundaries fall at an arbitrary bit position relative to the characters the transmitter sent. This block finds the true character boundary again. The transmitter places known alignment characters in the stream. The aligner keeps the previous and the current input word as a 20-bit window and tests all ten bit offsets against a search pattern in the same cycle. When a match is found it locks to that offset. From then on it emits every word shifted so that it starts on a character boundary.

The search pattern is a value with a per-bit care mask. One instance can therefore hunt for line-code commas, framing bytes or a private backplane code. In comma mode the pattern inputs are ignored and either polarity of the 7-bit comma prefix is accepted. A detect stage produces the per-offset hit vector. A separate control stage decides the offset, and it needs two sightings in a row at a new offset before it moves a lock that is already held. Bits enter most significant bit first: bit 9 of a word is the earliest serial bit.

Top module: `word_aligner`

## Requirements
- R1: The candidate at offset k (0..9) is bits [19-k:10-k] of the window {previous valid word, current valid word}. When the aligner is unlocked, it locks to the lowest offset that matches. From that word onward every output word is the candidate at the locked offset, so the output equals the transmitted characters.
- R2: With comma mode off, a candidate matches when ((candidate XOR patValue) AND patMask) is zero. Bits whose mask bit is 0 are ignored.
- R3: With comma mode on, patValue and patMask are ignored. A candidate matches when its bits [9:3] equal 7'b0011111 or 7'b1100000.
- R4: Each valid input word produces exactly one output word, with alignValid high for one cycle, two clock edges after the edge that samples the input.
- R5: patDetect is high together with an output word exactly when the candidate at the offset used for that word matches.
- R6: While locked, a match seen only at a different offset moves the lock only when the next word that holds any match also matches only at that same new offset. A match at the locked offset, or at another offset, in between cancels the pending move.
- R7: aligned stays 0 until the first match and then stays 1 until reset.
- R8: Cycles with rawValid low change no state and produce no output word.
- R9: After reset, alignValid, aligned, patDetect and alignWord are all 0. The previous word starts as zero and the offset starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawWord | input | 10 | Unaligned word from the deserializer, bit 9 earliest |
| rawValid | input | 1 | rawWord carries a word this cycle |
| patValue | input | 10 | Search pattern value |
| patMask | input | 10 | Search pattern care mask, 1 = compare |
| commaMode | input | 1 | 1 = search for either comma prefix polarity |
| alignWord | output | 10 | Word shifted onto the character boundary |
| alignValid | output | 1 | alignWord is new this cycle |
| aligned | output | 1 | The aligner has locked to an offset |
| patDetect | output | 1 | The current output word holds the pattern |

## Verification
The stream is built as a serial bit sequence and cut into words at a chosen starting slip. Bits are then inserted later to move the boundary. A design that switched its offset on the first foreign sighting would shift its output one alignment character too early. A design that did not cancel a pending move after a match at the held offset would jump to a stale offset. Gaps in rawValid catch a design that ages its window or emits words on idle cycles. Masked-out bits that differ from the alignment character catch a comparator that ignores the mask. Alternating comma polarities catch a comma search that accepts only one sign.

// File: rtl/wa_pkg.sv
package wa_pkg;
  parameter int WA_WORD_W = 10;
  localparam int WA_WIN_W = 2 * WA_WORD_W;
  localparam int WA_OFF_W = $clog2(WA_WORD_W);
  localparam int WA_COMMA_W = 7;
  localparam logic [WA_COMMA_W-1:0] WA_COMMA_NEG = 7'b0011111;
  localparam logic [WA_COMMA_W-1:0] WA_COMMA_POS = ~WA_COMMA_NEG;

  typedef logic [WA_WORD_W-1:0] wordT;
  typedef logic [WA_OFF_W-1:0] offT;

  // strobes from control to datapath
  typedef struct packed {
    logic adv;    // a window is being turned into an output word
    offT  sel;    // offset used for that word
    logic mark;   // that word holds the pattern
  } ctrlT;
endpackage

// File: rtl/wa_detect.sv
module wa_detect
  import wa_pkg::*;
(
  input  logic [WA_WIN_W-1:0] window,
  input  wordT                patValue,
  input  wordT                patMask,
  input  logic                commaMode,
  output wordT                hitVec
);
  for (genvar k = 0; k < WA_WORD_W; k++) begin : g_off
    wordT cand;
    logic patHit;
    logic commaHit;
    assign cand     = window[WA_WIN_W-1-k -: WA_WORD_W];
    assign patHit   = ((cand ^ patValue) & patMask) == '0;
    assign commaHit = (cand[WA_WORD_W-1 -: WA_COMMA_W] == WA_COMMA_NEG) ||
                      (cand[WA_WORD_W-1 -: WA_COMMA_W] == WA_COMMA_POS);
    assign hitVec[k] = commaMode ? commaHit : patHit;
  end
endmodule

// File: rtl/wa_datapath.sv
module wa_datapath
  import wa_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  wordT rawWord,
  input  logic rawValid,
  input  wordT patValue,
  input  wordT patMask,
  input  logic commaMode,
  input  ctrlT ctrl,
  output wordT s1Hit,
  output logic s1Valid,
  output wordT alignWord,
  output logic alignValid,
  output logic patDetect
);
  localparam int SHIFT_TOP = WA_WIN_W - 1;

  wordT prevWord;
  logic [WA_WIN_W-1:0] s1Win;
  wordT hitNow;
  wordT shifted;

  wa_detect uDet (
    .window    ({prevWord, rawWord}),
    .patValue  (patValue),
    .patMask   (patMask),
    .commaMode (commaMode),
    .hitVec    (hitNow)
  );

  assign shifted = s1Win[SHIFT_TOP - int'(ctrl.sel) -: WA_WORD_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWord   <= '0;
      s1Win      <= '0;
      s1Hit      <= '0;
      s1Valid    <= 1'b0;
      alignWord  <= '0;
      alignValid <= 1'b0;
      patDetect  <= 1'b0;
    end else begin
      s1Valid <= rawValid;
      if (rawValid) begin
        prevWord <= rawWord;
        s1Win    <= {prevWord, rawWord};
        s1Hit    <= hitNow;
      end
      alignValid <= ctrl.adv;
      patDetect  <= ctrl.mark;
      if (ctrl.adv) alignWord <= shifted;
    end
  end
endmodule

// File: rtl/wa_control.sv
module wa_control
  import wa_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic s1Valid,
  input  wordT s1Hit,
  output ctrlT ctrl,
  output logic aligned
);
  offT  curOff, nextOff;
  offT  pendOff, nextPendOff;
  logic pendValid, nextPendValid;
  logic nextLocked;
  offT  firstOff;
  logic anyHit;
  logic hitCur;

  always_comb begin
    firstOff = '0;
    for (int k = WA_WORD_W - 1; k >= 0; k--) begin
      if (s1Hit[k]) firstOff = offT'(k);
    end
  end

  assign anyHit = |s1Hit;
  assign hitCur = s1Hit[curOff];

  always_comb begin
    nextOff       = curOff;
    nextLocked    = aligned;
    nextPendOff   = pendOff;
    nextPendValid = pendValid;
    if (s1Valid) begin
      if (!aligned) begin
        if (anyHit) begin
          nextOff       = firstOff;
          nextLocked    = 1'b1;
          nextPendValid = 1'b0;
        end
      end else if (hitCur) begin
        nextPendValid = 1'b0;
      end else if (anyHit) begin
        if (pendValid && pendOff == firstOff) begin
          nextOff       = firstOff;
          nextPendValid = 1'b0;
        end else begin
          nextPendOff   = firstOff;
          nextPendValid = 1'b1;
        end
      end
    end
  end

  assign ctrl.adv  = s1Valid;
  assign ctrl.sel  = nextOff;
  assign ctrl.mark = s1Valid && s1Hit[nextOff];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOff    <= '0;
      aligned   <= 1'b0;
      pendOff   <= '0;
      pendValid <= 1'b0;
    end else begin
      curOff    <= nextOff;
      aligned   <= nextLocked;
      pendOff   <= nextPendOff;
      pendValid <= nextPendValid;
    end
  end
endmodule

// File: rtl/word_aligner.sv
module word_aligner
  import wa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [9:0] rawWord,
  input  logic       rawValid,
  input  logic [9:0] patValue,
  input  logic [9:0] patMask,
  input  logic       commaMode,
  output logic [9:0] alignWord,
  output logic       alignValid,
  output logic       aligned,
  output logic       patDetect
);
  ctrlT ctrl;
  wordT s1Hit;
  logic s1Valid;

  wa_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .rawWord    (rawWord),
    .rawValid   (rawValid),
    .patValue   (patValue),
    .patMask    (patMask),
    .commaMode  (commaMode),
    .ctrl       (ctrl),
    .s1Hit      (s1Hit),
    .s1Valid    (s1Valid),
    .alignWord  (alignWord),
    .alignValid (alignValid),
    .patDetect  (patDetect)
  );

  wa_control uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .s1Valid (s1Valid),
    .s1Hit   (s1Hit),
    .ctrl    (ctrl),
    .aligned (aligned)
  );
endmodule

// File: rtl/wa_checker.sv
module wa_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rawValid,
  input logic [9:0] patValue,
  input logic [9:0] patMask,
  input logic       commaMode,
  input logic [9:0] alignWord,
  input logic       alignValid,
  input logic       aligned,
  input logic       patDetect
);
  // R4: every accepted word leaves two edges later
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    rawValid |=> ##1 alignValid);

  // R8: no output word without an accepted input two edges earlier
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    alignValid |-> $past(rawValid, 2));

  // R5: a detect pulse only rides on a locked output word
  assert_detect_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    patDetect |-> (alignValid && aligned));

  // R2: with a steady pattern, a flagged word honours the masked compare
  assert_detect_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (patDetect && !commaMode && $stable(commaMode) && $stable(patValue) && $stable(patMask))
      |-> (((alignWord ^ patValue) & patMask) == 10'd0));

  // R3: with comma mode steady, a flagged word starts with a comma prefix
  assert_detect_comma_R3: assert property (@(posedge clk) disable iff (!rstN)
    (patDetect && commaMode && $stable(commaMode))
      |-> (alignWord[9:3] == 7'b0011111 || alignWord[9:3] == 7'b1100000));

  // R7: lock is never dropped outside reset
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(aligned));
endmodule

bind word_aligner wa_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rawValid   (rawValid),
  .patValue   (patValue),
  .patMask    (patMask),
  .commaMode  (commaMode),
  .alignWord  (alignWord),
  .alignValid (alignValid),
  .aligned    (aligned),
  .patDetect  (patDetect)
);

// File: tb/sim_word_aligner.sv
`timescale 1ns/1ps
module sim_word_aligner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] rawWord = '0;
  logic       rawValid = 1'b0;
  logic [9:0] patValue = '0;
  logic [9:0] patMask = '0;
  logic       commaMode = 1'b0;
  logic [9:0] alignWord;
  logic       alignValid, aligned, patDetect;

  always #10 clk = ~clk;

  word_aligner u0 (
    .clk(clk), .rstN(rstN), .rawWord(rawWord), .rawValid(rawValid),
    .patValue(patValue), .patMask(patMask), .commaMode(commaMode),
    .alignWord(alignWord), .alignValid(alignValid), .aligned(aligned),
    .patDetect(patDetect)
  );

  localparam logic [9:0] KNEG = 10'b0011111010;
  localparam logic [9:0] KPOS = 10'b1100000101;
  localparam logic [9:0] DA   = 10'b1010101010;
  localparam logic [9:0] DB   = 10'b0110101010;

  typedef struct {
    logic [9:0] word;
    logic       lock;
    logic       det;
    int         due;
    string      tag;
  } expT;

  expT  expQ[$];
  logic bitQ[$];
  int   edgeCnt = 0;
  int   nChecks = 0;
  int   nFails = 0;
  string curTag = "R1";

  // requirement model
  logic [9:0] mPrev = '0;
  int   mOff = 0;
  logic mLock = 1'b0;
  int   mPendOff = 0;
  logic mPendV = 1'b0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] hitsOf(input logic [19:0] win);
    logic [9:0] h;
    for (int k = 0; k < 10; k++) begin
      logic [9:0] c;
      c = win[19-k -: 10];
      if (commaMode) h[k] = (c[9:3] == 7'b0011111) || (c[9:3] == 7'b1100000);
      else           h[k] = ((c ^ patValue) & patMask) == 10'd0;
    end
    return h;
  endfunction

  task automatic driveWord(input logic [9:0] w);
    logic [19:0] win;
    logic [9:0]  h;
    int first;
    expT e;
    win = {mPrev, w};
    h = hitsOf(win);
    first = -1;
    for (int k = 9; k >= 0; k--) if (h[k]) first = k;
    if (!mLock) begin
      if (first >= 0) begin mOff = first; mLock = 1'b1; mPendV = 1'b0; end
    end else if (h[mOff]) begin
      mPendV = 1'b0;
    end else if (first >= 0) begin
      if (mPendV && mPendOff == first) begin mOff = first; mPendV = 1'b0; end
      else begin mPendOff = first; mPendV = 1'b1; end
    end
    e.word = win[19-mOff -: 10];
    e.lock = mLock;
    e.det  = h[mOff];
    e.due  = edgeCnt + 2;
    e.tag  = curTag;
    expQ.push_back(e);
    mPrev = w;
    rawWord  = w;
    rawValid = 1'b1;
    @(negedge clk);
    rawValid = 1'b0;
  endtask

  task automatic pushChar(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) bitQ.push_back(c[i]);
  endtask

  task automatic pushBits(input int n, input logic [9:0] b);
    for (int i = n - 1; i >= 0; i--) bitQ.push_back(b[i]);
  endtask

  task automatic sendAll(input int gap);
    while (bitQ.size() >= 10) begin
      logic [9:0] w;
      for (int i = 9; i >= 0; i--) w[i] = bitQ.pop_front();
      driveWord(w);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && alignValid) begin
        if (expQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R8: actual output word %b expected none", alignWord);
        end else begin
          expT e;
          e = expQ.pop_front();
          check(e.tag, alignWord, e.word);
          check("R7", {9'd0, aligned}, {9'd0, e.lock});
          check("R5", {9'd0, patDetect}, {9'd0, e.det});
          check("R4", 10'(edgeCnt - e.due), 10'd0);
        end
      end
    end
  end

  task automatic runAll();
    // R9: reset state
    idle(3);
    check("R9", alignWord, 10'd0);
    check("R9", {7'd0, alignValid, aligned, patDetect}, 10'd0);
    rstN = 1'b1;
    idle(2);
    check("R9", {7'd0, alignValid, aligned, patDetect}, 10'd0);

    // R1: full-mask search, stream starts three bits into a character
    patValue = KNEG; patMask = 10'h3FF; commaMode = 1'b0;
    curTag = "R1";
    pushBits(3, 10'b101);
    pushChar(DA); pushChar(DB); pushChar(DA); pushChar(KNEG);
    pushChar(DA); pushChar(DB); pushChar(DA); pushChar(KNEG); pushChar(DA);
    sendAll(0);

    // R8: gaps between valid words
    curTag = "R8";
    pushChar(DB); pushChar(KNEG); pushChar(DA); pushChar(DB);
    sendAll(2);

    // R6: single foreign sighting then a sighting at the held offset
    curTag = "R6";
    pushBits(2, 10'b10);
    pushChar(DA); pushChar(KNEG); pushChar(DA);
    pushBits(8, 10'b10101010);
    pushChar(DA); pushChar(KNEG); pushChar(DA); pushChar(DA);
    sendAll(0);
    // R6: two sightings at a new offset move the lock
    pushBits(4, 10'b1010);
    pushChar(DA); pushChar(KNEG); pushChar(DA); pushChar(DB);
    pushChar(KNEG); pushChar(DA); pushChar(KNEG); pushChar(DA);
    sendAll(0);
    idle(4);

    // R3: comma mode, pattern inputs hold junk, both polarities
    curTag = "R3";
    commaMode = 1'b1; patValue = 10'h155; patMask = 10'h3FF;
    idle(3);
    pushChar(DA); pushChar(KPOS); pushChar(DB); pushChar(KNEG);
    pushChar(DA); pushChar(KPOS); pushChar(DA);
    sendAll(0);
    idle(4);

    // R2: masked compare, low three bits differ from the character but are ignored
    curTag = "R2";
    commaMode = 1'b0; patValue = 10'b0011111101; patMask = 10'b1111111000;
    idle(3);
    pushChar(DA); pushChar(KNEG); pushChar(DB); pushChar(KPOS);
    pushChar(DA); pushChar(KNEG); pushChar(DA);
    sendAll(0);
    idle(6);
    check("R4", 10'(expQ.size()), 10'd0);
  endtask

  initial begin
    logic timedOut;
    timedOut = 1'b0;
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule